// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the SDRAM command bus from reset until the memory is ready for ordinary traffic. After reset it holds the bus at NOP for a programmable power-up interval. It then precharges every bank, issues two auto-refresh commands and loads the mode register. Each wait is a parameter counted in clock cycles, so one design serves any clock rate once the nanosecond figures are converted.

The mode word comes in on an input and passes through a sanitizer before it is loaded. Reserved and test-mode fields are cleared, and an illegal latency code is replaced by a safe one. A sticky ready flag rises a fixed number of cycles after the mode load. Downstream controller logic waits for that flag before it takes over the bus.

All outputs are registered. Clock enable stays high throughout. Every cycle that carries no step command carries a NOP.

Top module: `sdram_init_seq`

## Requirements
- R1: Clock enable `cke` is high in every cycle, during reset and after it.
- R2: From reset release, the bus carries NOP (`{cs_n,ras_n,cas_n,we_n}` = 0111) for exactly `PWRUP_CYC` cycles before any other command.
- R3: In cycle `PWRUP_CYC+1` after reset release, a PRECHARGE (0010) is issued with address bit 10 high, meaning all banks, and every other address bit low.
- R4: The first AUTO REFRESH (0001) is issued exactly `TRP_CYC` cycles after the precharge.
- R5: The second AUTO REFRESH is issued exactly `TRFC_CYC` cycles after the first.
- R6: LOAD MODE (0000) is issued exactly `TRFC_CYC` cycles after the second refresh, with `ba` = 00 and the sanitized mode word on `addr`.
- R7: The latency field of the mode word is bits 6:4. The values 010 and 011 pass unchanged. Any other value is replaced by the `SAFE_CL` code, which is 011 by default.
- R8: In the loaded word, bits 8:7 (operating mode) and bits 12:10 are forced to 0. Bits 9 and 3:0 pass unchanged.
- R9: `init_done` is low until `TMRD_CYC` cycles after the mode load. From then on it stays high until the next reset.
- R10: Exactly four non-NOP commands appear per sequence, and only NOP is driven once `init_done` is high.
- R11: Reset asserted in the middle of a sequence drops `init_done` and restarts the full sequence, including the power-up wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_cfg | input | ADDR_W | Requested mode word, sampled in the mode-load cycle |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address / opcode bus |
| ba | output | BA_W | Bank select |
| init_done | output | 1 | Sequence complete; bus may be handed over |

## Verification
On every cycle, the checker confirms the following:
- clock enable stays high;
- the precharge selects all banks;
- each command sits at its exact distance from the one before it;
- the loaded word has legal latency and cleared reserved fields;
- the ready flag rises only the right number of cycles after the mode load and never falls;
- the bus stays quiet once the flag is high.

Only the bench scenarios can show a few things: that the power-up wait has the exact length, that every pass-through bit of the mode word survives (the vector table covers this), and that a reset in the middle of a sequence restarts it from the power-up wait.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  // Command codes packed as {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LMR = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } sdram_cmd_e;

  typedef enum logic [2:0] {
    ST_POWERUP   = 3'd0,
    ST_PRE_WAIT  = 3'd1,
    ST_REF1_WAIT = 3'd2,
    ST_REF2_WAIT = 3'd3,
    ST_MRD_WAIT  = 3'd4,
    ST_READY     = 3'd5
  } init_state_e;

  // Mode word field positions
  localparam int MR_CL_LSB  = 4;
  localparam int MR_CL_MSB  = 6;
  localparam int MR_OP_LSB  = 7;
  localparam int MR_OP_MSB  = 8;
  localparam int MR_RSV_LSB = 10;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_mode_fix.sv
module sdram_mode_fix
  import sdram_init_pkg::*;
#(
  parameter int MODE_W  = 13,
  parameter int SAFE_CL = 3
) (
  input  logic [MODE_W-1:0] mode_raw,
  output logic [MODE_W-1:0] mode_safe
);

  localparam int CL_W = MR_CL_MSB - MR_CL_LSB + 1;

  logic [CL_W-1:0] cl_fallback;
  logic [CL_W-1:0] cl_req;
  logic            cl_legal;

  generate
    if (SAFE_CL == 2) begin : g_fallback_cl2
      assign cl_fallback = CL_W'(2);
    end else begin : g_fallback_cl3
      assign cl_fallback = CL_W'(3);
    end
  endgenerate

  assign cl_req   = mode_raw[MR_CL_MSB:MR_CL_LSB];
  assign cl_legal = (cl_req == CL_W'(2)) || (cl_req == CL_W'(3));

  always_comb begin
    mode_safe = mode_raw;
    mode_safe[MR_OP_MSB:MR_OP_LSB]   = '0;
    mode_safe[MODE_W-1:MR_RSV_LSB]   = '0;
    if (!cl_legal) begin
      mode_safe[MR_CL_MSB:MR_CL_LSB] = cl_fallback;
    end
  end

endmodule

// File: rtl/sdram_wait_timer.sv
module sdram_wait_timer #(
  parameter int CNT_W   = 8,
  parameter int RST_VAL = 100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= CNT_W'(RST_VAL);
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int BA_W      = 2,
  parameter int AP_BIT    = 10,
  parameter int PWRUP_CYC = 12500,
  parameter int TRP_CYC   = 3,
  parameter int TRFC_CYC  = 9,
  parameter int TMRD_CYC  = 2,
  parameter int SAFE_CL   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] mode_cfg,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba,
  output logic              init_done
);

  localparam int MAX_WAIT = max2(max2(PWRUP_CYC, TRP_CYC), max2(TRFC_CYC, TMRD_CYC));
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);

  init_state_e       st_q, st_d;
  sdram_cmd_e        cmd_q, cmd_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              done_q, done_d;

  logic              tmr_load;
  logic [CNT_W-1:0]  tmr_val;
  logic              tmr_expired;
  logic [ADDR_W-1:0] mode_safe;

  sdram_mode_fix #(
    .MODE_W  (ADDR_W),
    .SAFE_CL (SAFE_CL)
  ) u_mode_fix (
    .mode_raw  (mode_cfg),
    .mode_safe (mode_safe)
  );

  sdram_wait_timer #(
    .CNT_W   (CNT_W),
    .RST_VAL (PWRUP_CYC)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  always_comb begin
    st_d     = st_q;
    cmd_d    = CMD_NOP;
    addr_d   = '0;
    done_d   = done_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (st_q)
      ST_POWERUP: begin
        if (tmr_expired) begin
          cmd_d          = CMD_PRE;
          addr_d[AP_BIT] = 1'b1;
          st_d           = ST_PRE_WAIT;
          tmr_load       = 1'b1;
          tmr_val        = CNT_W'(TRP_CYC - 1);
        end
      end
      ST_PRE_WAIT: begin
        if (tmr_expired) begin
          cmd_d    = CMD_REF;
          st_d     = ST_REF1_WAIT;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(TRFC_CYC - 1);
        end
      end
      ST_REF1_WAIT: begin
        if (tmr_expired) begin
          cmd_d    = CMD_REF;
          st_d     = ST_REF2_WAIT;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(TRFC_CYC - 1);
        end
      end
      ST_REF2_WAIT: begin
        if (tmr_expired) begin
          cmd_d    = CMD_LMR;
          addr_d   = mode_safe;
          st_d     = ST_MRD_WAIT;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(TMRD_CYC - 1);
        end
      end
      ST_MRD_WAIT: begin
        if (tmr_expired) begin
          done_d = 1'b1;
          st_d   = ST_READY;
        end
      end
      ST_READY: begin
        done_d = 1'b1;
      end
      default: begin
        st_d = ST_POWERUP;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_POWERUP;
      cmd_q  <= CMD_NOP;
      addr_q <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cmd_q  <= cmd_d;
      addr_q <= addr_d;
      done_q <= done_d;
    end
  end

  assign cke       = 1'b1;
  assign cs_n      = cmd_q[3];
  assign ras_n     = cmd_q[2];
  assign cas_n     = cmd_q[1];
  assign we_n      = cmd_q[0];
  assign addr      = addr_q;
  assign ba        = '0;
  assign init_done = done_q;

endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk #(
  parameter int ADDR_W   = 13,
  parameter int AP_BIT   = 10,
  parameter int TRP_CYC  = 3,
  parameter int TRFC_CYC = 9,
  parameter int TMRD_CYC = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              cke,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr,
  input logic              init_done
);

  logic [3:0]  cmd;
  logic        is_nop, is_pre, is_ref, is_lmr;
  logic [3:0]  last_cmd;
  logic [31:0] gap;
  logic [2:0]  n_cmds;
  logic        seen_lmr;

  assign cmd    = {cs_n, ras_n, cas_n, we_n};
  assign is_nop = (cmd == 4'b0111);
  assign is_pre = (cmd == 4'b0010);
  assign is_ref = (cmd == 4'b0001);
  assign is_lmr = (cmd == 4'b0000);

  always_ff @(posedge clk) begin
    if (rst) begin
      last_cmd <= 4'b0111;
      gap      <= '0;
      n_cmds   <= '0;
      seen_lmr <= 1'b0;
    end else if (!is_nop) begin
      last_cmd <= cmd;
      gap      <= 32'd1;
      if (n_cmds != 3'd7) n_cmds <= n_cmds + 3'd1;
      if (is_lmr) seen_lmr <= 1'b1;
    end else if (gap != 32'hFFFF_FFFF) begin
      gap <= gap + 32'd1;
    end
  end

  assert_cke_high_R1: assert property (@(posedge clk) disable iff (rst) cke);
  assert_pre_all_banks_R3: assert property (@(posedge clk) disable iff (rst)
    is_pre |-> addr[AP_BIT]);
  assert_ref1_spacing_R4: assert property (@(posedge clk) disable iff (rst)
    (is_ref && last_cmd == 4'b0010) |-> gap == 32'(TRP_CYC));
  assert_ref2_spacing_R5: assert property (@(posedge clk) disable iff (rst)
    (is_ref && last_cmd == 4'b0001) |-> gap == 32'(TRFC_CYC));
  assert_lmr_spacing_R6: assert property (@(posedge clk) disable iff (rst)
    is_lmr |-> (last_cmd == 4'b0001 && gap == 32'(TRFC_CYC)));
  assert_lmr_latency_R7: assert property (@(posedge clk) disable iff (rst)
    is_lmr |-> (addr[6:4] == 3'd2 || addr[6:4] == 3'd3));
  assert_lmr_reserved_R8: assert property (@(posedge clk) disable iff (rst)
    is_lmr |-> (addr[ADDR_W-1:10] == '0 && addr[8:7] == 2'b00));
  assert_done_after_mrd_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(init_done) |-> (seen_lmr && gap == 32'(TMRD_CYC)));
  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);
  assert_quiet_after_done_R10: assert property (@(posedge clk) disable iff (rst)
    init_done |-> is_nop);
  assert_cmd_legal_R10: assert property (@(posedge clk) disable iff (rst)
    is_nop || is_pre || is_ref || is_lmr);
  assert_cmd_count_R10: assert property (@(posedge clk) disable iff (rst)
    !is_nop |-> n_cmds < 3'd4);

endmodule

bind sdram_init_seq sdram_init_seq_chk #(
  .ADDR_W   (ADDR_W),
  .AP_BIT   (AP_BIT),
  .TRP_CYC  (TRP_CYC),
  .TRFC_CYC (TRFC_CYC),
  .TMRD_CYC (TMRD_CYC)
) u_init_chk (
  .clk       (clk),
  .rst       (rst),
  .cke       (cke),
  .cs_n      (cs_n),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .we_n      (we_n),
  .addr      (addr),
  .init_done (init_done)
);

// File: tb/tb_sdram_init_seq.sv
module tb_sdram_init_seq;

  localparam int ADDR_W = 13;
  localparam int BA_W   = 2;
  localparam int P      = 20;
  localparam int TRP    = 3;
  localparam int TRFC   = 9;
  localparam int TMRD   = 2;

  localparam int C_PRE  = P + 1;
  localparam int C_REF1 = C_PRE + TRP;
  localparam int C_REF2 = C_REF1 + TRFC;
  localparam int C_LMR  = C_REF2 + TRFC;
  localparam int C_DONE = C_LMR + TMRD;
  localparam int C_LAST = C_DONE + 8;

  localparam logic [3:0] E_NOP = 4'b0111;
  localparam logic [3:0] E_PRE = 4'b0010;
  localparam logic [3:0] E_REF = 4'b0001;
  localparam logic [3:0] E_LMR = 4'b0000;

  // {requested mode word, expected loaded word}
  localparam int NVEC = 7;
  localparam logic [25:0] VEC [NVEC] = '{
    {13'h0032, 13'h0032},
    {13'h0023, 13'h0023},
    {13'h1FFF, 13'h023F},
    {13'h0000, 13'h0030},
    {13'h0288, 13'h0238},
    {13'h0C5A, 13'h003A},
    {13'h0124, 13'h0024}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] mode_cfg = '0;
  logic              cke, cs_n, ras_n, cas_n, we_n, init_done;
  logic [ADDR_W-1:0] addr;
  logic [BA_W-1:0]   ba;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sdram_init_seq #(
    .ADDR_W    (ADDR_W),
    .BA_W      (BA_W),
    .AP_BIT    (10),
    .PWRUP_CYC (P),
    .TRP_CYC   (TRP),
    .TRFC_CYC  (TRFC),
    .TMRD_CYC  (TMRD),
    .SAFE_CL   (3)
  ) dut (
    .clk       (clk),
    .rst       (rst),
    .mode_cfg  (mode_cfg),
    .cke       (cke),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .addr      (addr),
    .ba        (ba),
    .init_done (init_done)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] bus_cmd();
    return {cs_n, ras_n, cas_n, we_n};
  endfunction

  // Hold reset for a few cycles and check the reset state (R1, R2, R9)
  task automatic apply_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(cke == 1'b1, "R1 reset cke", 32'(cke), 32'd1);
    check(bus_cmd() == E_NOP, "R2 reset cmd", 32'(bus_cmd()), 32'(E_NOP));
    check(init_done == 1'b0, "R9 reset done", 32'(init_done), 32'd0);
    rst = 1'b0;
  endtask

  // Walk cycles 1..last after reset release and compare every output
  task automatic walk(input int last, input logic [ADDR_W-1:0] exp_mode, input string mtag);
    for (int n = 1; n <= last; n++) begin
      logic [3:0]        ec;
      logic [ADDR_W-1:0] ea;
      string             tg;
      @(negedge clk);
      ea = '0;
      if (n <= P)            begin ec = E_NOP; tg = "R2 wait";  end
      else if (n == C_PRE)   begin ec = E_PRE; tg = "R3 pre"; ea = 13'h0400; end
      else if (n == C_REF1)  begin ec = E_REF; tg = "R4 ref1";  end
      else if (n == C_REF2)  begin ec = E_REF; tg = "R5 ref2";  end
      else if (n == C_LMR)   begin ec = E_LMR; tg = "R6 load"; ea = exp_mode; end
      else                   begin ec = E_NOP; tg = "R10 idle"; end
      check(bus_cmd() == ec, tg, 32'(bus_cmd()), 32'(ec));
      if (n == C_LMR) begin
        check(addr == ea, mtag, 32'(addr), 32'(ea));
        check(ba == '0, "R6 bank", 32'(ba), 32'd0);
      end else if (n == C_PRE) begin
        check(addr == ea, "R3 addr", 32'(addr), 32'(ea));
      end
      check(init_done == (n >= C_DONE), "R9 done", 32'(init_done), 32'(n >= C_DONE));
      check(cke == 1'b1, "R1 cke", 32'(cke), 32'd1);
    end
  endtask

  initial begin
    // Vector table: one full sequence per requested mode word (R7, R8)
    for (int v = 0; v < NVEC; v++) begin
      mode_cfg = VEC[v][25:13];
      apply_reset();
      walk(C_LAST, VEC[v][12:0], "R7,R8 mode word");
    end

    // R11: reset in the middle of the sequence restarts it from the wait
    mode_cfg = 13'h0032;
    apply_reset();
    walk(C_PRE + 4, 13'h0032, "R7,R8 mode word");
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(bus_cmd() == E_NOP, "R11 reset cmd", 32'(bus_cmd()), 32'(E_NOP));
    check(init_done == 1'b0, "R11 reset done", 32'(init_done), 32'd0);
    rst = 1'b0;
    walk(C_LAST, 13'h0032, "R11 restart mode word");

    // R11: reset after completion drops done and reruns the wait
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(init_done == 1'b0, "R11 done cleared", 32'(init_done), 32'd0);
    rst = 1'b0;
    mode_cfg = 13'h0023;
    walk(C_LAST, 13'h0023, "R11 rerun mode word");

    // R10: long idle after completion stays NOP with done held
    for (int k = 0; k < 50; k++) begin
      @(negedge clk);
      if (k % 10 == 0) begin
        check(bus_cmd() == E_NOP, "R10 quiet", 32'(bus_cmd()), 32'(E_NOP));
        check(init_done == 1'b1, "R9 sticky", 32'(init_done), 32'd1);
      end
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

endmodule